// File: doc/BRIEF.md
# Multichannel Summing Output Formatter

This block takes four sample channels (A, B, C, D), each with an in-phase (I) and a quadrature (Q) 16-bit sample per clock. It adds them in the grouping a static configuration word selects and places the results on four 16-bit output ports. The word selects:

- the output rate (half, full or double);
- real or complex output;
- the grouping (no summing, pairs, or all four);
- whether an external partial sum from an upstream device is added;
- standard 16-bit or wide 22-bit result resolution.

At half rate, I and Q share one port on alternating clocks, and a phase output marks which one is present. At double rate, channels A and C carry even-indexed samples and channels B and D carry the odd-indexed ones, so two samples of one stream leave on separate ports in the same clock.

Ports 2 and 3 can act as inputs for the external cascade sum. The block then holds their output-enables low and reads the pad values on the separate `xin` input. In wide mode a 22-bit result leaves as 16 upper bits on port 0 and 6 lower bits on port 1. The external 22-bit input arrives the same way on ports 2 and 3.

Top module: `chsum_fmt`

## Requirements
- R1: `cfg_word` holds these fields:
  - bits [1:0]: rate, 0 = half, 1 = full, 2 = double;
  - bit 2: complex;
  - bits [5:3]: grouping, 4 = none, 2 = pairs, 1 = all;
  - bit 6: external sum;
  - bit 7: wide.

  Any combination not listed in R2 to R7 is unsupported. It drives all ports to zero with all enables low and raises `cfg_err`. Supported combinations keep `cfg_err` low.
- R2: Full rate, real, standard, no external sum:
  - grouping 4: ports 0..3 carry A.I, B.I, C.I, D.I;
  - grouping 2: port 0 = A.I+B.I, port 1 = C.I+D.I;
  - grouping 1: port 0 = A.I+B.I+C.I+D.I.
- R3: Full rate, complex, no external sum:
  - grouping 2: ports 0..3 carry (A+B).I, (A+B).Q, (C+D).I, (C+D).Q;
  - grouping 1: port 0 = total I, port 1 = total Q.
- R4: Half rate, complex. An internal phase starts at 0 after reset and toggles every clock. Data are selected as I on phase 0 and as Q on phase 1. `phase_o` shows the phase of the data presently on the ports.
  - grouping 4: channel k goes to port k;
  - grouping 2: A+B goes to port 0 and C+D to port 1;
  - grouping 1: the total goes to port 0.
- R5: Double rate (no external sum):
  - real, grouping 2: ports 0..3 carry A.I, B.I, C.I, D.I;
  - real, grouping 1: port 0 = A.I+C.I (even), port 1 = B.I+D.I (odd);
  - complex, grouping 1: ports 0..3 carry A.I+C.I, A.Q+C.Q, B.I+D.I, B.Q+D.Q.
- R6: The external sum applies with grouping 1 only. `xin[15:0]` is the pad value of port 2 and `xin[31:16]` that of port 3.
  - full real: port 0 = total I + port 2 value;
  - full complex: port 0 = total I + port 2 value, and port 1 = total Q + port 3 value;
  - half complex: port 0 = phase-selected total + port 2 value;
  - double real: port 0 = A.I+C.I + port 2 value, and port 1 = B.I+D.I + port 3 value.

  Ports 2 and 3 keep their enables low.
- R7: Wide mode (external sum on, grouping 1, full real or half complex). The 22-bit sum is channel sum times 64 plus the external value {port 2 value, port 3 value bits [5:0]}. Its bits [21:6] go on port 0. Its bits [5:0] go on port 1 bits [5:0], with the upper bits of port 1 zero.
- R8: Results saturate to the signed 16-bit range in standard mode and to the signed 22-bit range in wide mode.
- R9: Every port not used in the selected mode drives zero with its enable low.
- R10: Outputs are registered. Inputs sampled at a rising edge appear after that edge and not before. During reset all ports, enables, `cfg_err` and `phase_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| cfg_word | input | 8 | Static configuration word (fields in R1) |
| ch_i | input | 64 | I samples, channel k in bits [16k+15:16k] |
| ch_q | input | 64 | Q samples, channel k in bits [16k+15:16k] |
| xin | input | 32 | Pad input values of port 2 (bits 15:0) and port 3 (bits 31:16) |
| pad_out | output | 64 | Port k data in bits [16k+15:16k] |
| pad_oe | output | 4 | Port output-enables |
| phase_o | output | 1 | Phase of the present half-rate data, 0 = I, 1 = Q |
| cfg_err | output | 1 | Unsupported configuration |

## Verification
Every supported mode is run with random full-range channel and external values. This separates wrong channel-to-port routing, swapped I/Q selection and a missing external term, because each channel contributes a distinct value. Half-rate modes run over consecutive clocks, so an inverted or stuck phase shows as I/Q swapped against the bench's own phase count. Directed all-maximum and all-minimum inputs push both the 16-bit and the 22-bit saturation limits. A small wide-mode case tells the low six bits apart from the upper sixteen. A list of unsupported words checks that every port turns off and the error flag rises.

// File: rtl/csf_pkg.sv
package csf_pkg;
  localparam int NPORT = 4;
  localparam int NCH   = 4;

  typedef enum logic [1:0] {RATE_HALF = 2'd0, RATE_FULL = 2'd1, RATE_DBL = 2'd2, RATE_BAD = 2'd3} rate_e;

  // Configuration word layout: [7] wide, [6] xsum, [5:3] grouping, [2] complex, [1:0] rate
  typedef struct packed {
    logic       wide;
    logic       xsum;
    logic [2:0] nsig;
    logic       cplx;
    rate_e      rate;
  } cfg_t;

  typedef enum logic [1:0] {PICK_I = 2'd0, PICK_Q = 2'd1, PICK_PH = 2'd2} pick_e;
  typedef enum logic [1:0] {EXT_NONE = 2'd0, EXT_P2 = 2'd1, EXT_P3 = 2'd2} ext_e;
  typedef enum logic [1:0] {PART_STD = 2'd0, PART_HI = 2'd1, PART_LO = 2'd2} part_e;

  // What one output lane computes
  typedef struct packed {
    logic            on;
    logic [NCH-1:0]  mask;
    pick_e           pick;
    ext_e            ext;
    part_e           part;
  } lane_plan_t;

  localparam logic [NCH-1:0] M_AB  = 4'b0011;
  localparam logic [NCH-1:0] M_CD  = 4'b1100;
  localparam logic [NCH-1:0] M_EVN = 4'b0101;
  localparam logic [NCH-1:0] M_ODD = 4'b1010;
  localparam logic [NCH-1:0] M_ALL = 4'b1111;
endpackage

// File: rtl/csf_decode.sv
module csf_decode
  import csf_pkg::*;
(
  input  cfg_t                   cfg,
  output lane_plan_t [NPORT-1:0] plan,
  output logic                   err
);
  function automatic lane_plan_t mk(input logic [NCH-1:0] m, input pick_e p,
                                    input ext_e e, input part_e pt);
    mk = '{on: 1'b1, mask: m, pick: p, ext: e, part: pt};
  endfunction

  function automatic logic [NCH-1:0] one_hot(input int k);
    one_hot = '0;
    one_hot[k] = 1'b1;
  endfunction

  logic [5:0] key;

  always_comb begin
    plan = '0;
    err  = 1'b0;
    key  = {cfg.rate, cfg.cplx, cfg.nsig};
    if (!cfg.xsum && !cfg.wide) begin
      case (key)
        {2'd1, 1'b0, 3'd4}, {2'd2, 1'b0, 3'd2}:
          for (int k = 0; k < NPORT; k++) plan[k] = mk(one_hot(k), PICK_I, EXT_NONE, PART_STD);
        {2'd1, 1'b0, 3'd2}: begin
          plan[0] = mk(M_AB, PICK_I, EXT_NONE, PART_STD);
          plan[1] = mk(M_CD, PICK_I, EXT_NONE, PART_STD);
        end
        {2'd1, 1'b0, 3'd1}: plan[0] = mk(M_ALL, PICK_I, EXT_NONE, PART_STD);
        {2'd1, 1'b1, 3'd2}: begin
          plan[0] = mk(M_AB, PICK_I, EXT_NONE, PART_STD);
          plan[1] = mk(M_AB, PICK_Q, EXT_NONE, PART_STD);
          plan[2] = mk(M_CD, PICK_I, EXT_NONE, PART_STD);
          plan[3] = mk(M_CD, PICK_Q, EXT_NONE, PART_STD);
        end
        {2'd1, 1'b1, 3'd1}: begin
          plan[0] = mk(M_ALL, PICK_I, EXT_NONE, PART_STD);
          plan[1] = mk(M_ALL, PICK_Q, EXT_NONE, PART_STD);
        end
        {2'd0, 1'b1, 3'd4}:
          for (int k = 0; k < NPORT; k++) plan[k] = mk(one_hot(k), PICK_PH, EXT_NONE, PART_STD);
        {2'd0, 1'b1, 3'd2}: begin
          plan[0] = mk(M_AB, PICK_PH, EXT_NONE, PART_STD);
          plan[1] = mk(M_CD, PICK_PH, EXT_NONE, PART_STD);
        end
        {2'd0, 1'b1, 3'd1}: plan[0] = mk(M_ALL, PICK_PH, EXT_NONE, PART_STD);
        {2'd2, 1'b0, 3'd1}: begin
          plan[0] = mk(M_EVN, PICK_I, EXT_NONE, PART_STD);
          plan[1] = mk(M_ODD, PICK_I, EXT_NONE, PART_STD);
        end
        {2'd2, 1'b1, 3'd1}: begin
          plan[0] = mk(M_EVN, PICK_I, EXT_NONE, PART_STD);
          plan[1] = mk(M_EVN, PICK_Q, EXT_NONE, PART_STD);
          plan[2] = mk(M_ODD, PICK_I, EXT_NONE, PART_STD);
          plan[3] = mk(M_ODD, PICK_Q, EXT_NONE, PART_STD);
        end
        default: err = 1'b1;
      endcase
    end else if (cfg.xsum && !cfg.wide && cfg.nsig == 3'd1) begin
      case (key[5:3])
        {2'd1, 1'b0}: plan[0] = mk(M_ALL, PICK_I, EXT_P2, PART_STD);
        {2'd1, 1'b1}: begin
          plan[0] = mk(M_ALL, PICK_I, EXT_P2, PART_STD);
          plan[1] = mk(M_ALL, PICK_Q, EXT_P3, PART_STD);
        end
        {2'd0, 1'b1}: plan[0] = mk(M_ALL, PICK_PH, EXT_P2, PART_STD);
        {2'd2, 1'b0}: begin
          plan[0] = mk(M_EVN, PICK_I, EXT_P2, PART_STD);
          plan[1] = mk(M_ODD, PICK_I, EXT_P3, PART_STD);
        end
        default: err = 1'b1;
      endcase
    end else if (cfg.xsum && cfg.wide && cfg.nsig == 3'd1) begin
      case (key[5:3])
        {2'd1, 1'b0}: begin
          plan[0] = mk(M_ALL, PICK_I, EXT_P2, PART_HI);
          plan[1] = mk(M_ALL, PICK_I, EXT_P2, PART_LO);
        end
        {2'd0, 1'b1}: begin
          plan[0] = mk(M_ALL, PICK_PH, EXT_P2, PART_HI);
          plan[1] = mk(M_ALL, PICK_PH, EXT_P2, PART_LO);
        end
        default: err = 1'b1;
      endcase
    end else begin
      err = 1'b1;
    end
  end

  // R1: an error never comes with an enabled lane
  always_comb begin
    if (err) assert_err_no_lane_R1: assert (plan == '0);
  end
endmodule

// File: rtl/csf_lane.sv
module csf_lane
  import csf_pkg::*;
#(
  parameter int W    = 16,
  parameter int LSBW = 6,
  localparam int WW  = W + LSBW,
  localparam int SW  = WW + 3
) (
  input  lane_plan_t               plan,
  input  logic [NCH-1:0][W-1:0]    ch_i,
  input  logic [NCH-1:0][W-1:0]    ch_q,
  input  logic                     ph,
  input  logic signed [WW-1:0]     ext_p2,
  input  logic signed [WW-1:0]     ext_p3,
  output logic [W-1:0]             val
);
  localparam logic signed [SW-1:0] LIM_WHI = SW'({1'b0, {(WW-1){1'b1}}});
  localparam logic signed [SW-1:0] LIM_SHI = SW'({1'b0, {(W-1){1'b1}}, {LSBW{1'b0}}});
  localparam logic signed [SW-1:0] LIM_LO  = ~LIM_WHI;

  logic               use_q;
  logic signed [SW-1:0] term;
  logic signed [SW-1:0] acc;
  logic signed [SW-1:0] lim_hi;
  logic signed [SW-1:0] clip;

  always_comb begin
    use_q = (plan.pick == PICK_Q) || ((plan.pick == PICK_PH) && ph);
    acc   = '0;
    term  = '0;
    for (int k = 0; k < NCH; k++) begin
      if (plan.mask[k]) begin
        term = SW'($signed(use_q ? ch_q[k] : ch_i[k]));
        acc  = acc + (term <<< LSBW);
      end
    end
    case (plan.ext)
      EXT_P2:  acc = acc + SW'(ext_p2);
      EXT_P3:  acc = acc + SW'(ext_p3);
      default: acc = acc;
    endcase
    lim_hi = (plan.part == PART_STD) ? LIM_SHI : LIM_WHI;
    if (acc > lim_hi)      clip = lim_hi;
    else if (acc < LIM_LO) clip = LIM_LO;
    else                   clip = acc;
    if (!plan.on)                  val = '0;
    else if (plan.part == PART_LO) val = {{(W-LSBW){1'b0}}, clip[LSBW-1:0]};
    else                           val = clip[WW-1:LSBW];
  end

  // R8: the clipped value stays inside the range the lane mode allows
  always_comb begin
    assert_clip_range_R8: assert (clip <= lim_hi && clip >= LIM_LO);
  end
endmodule

// File: rtl/chsum_fmt.sv
module chsum_fmt
  import csf_pkg::*;
#(
  parameter int W    = 16,
  parameter int LSBW = 6,
  localparam int WW  = W + LSBW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           cfg_word,
  input  logic [NCH*W-1:0]     ch_i,
  input  logic [NCH*W-1:0]     ch_q,
  input  logic [2*W-1:0]       xin,
  output logic [NPORT*W-1:0]   pad_out,
  output logic [NPORT-1:0]     pad_oe,
  output logic                 phase_o,
  output logic                 cfg_err
);
  cfg_t                     cfg;
  lane_plan_t [NPORT-1:0]   plan;
  logic                     err_d;
  logic signed [WW-1:0]     ext_p2;
  logic signed [WW-1:0]     ext_p3;
  logic [NPORT-1:0][W-1:0]  val;
  logic [NPORT-1:0]         oe_d;
  logic                     ph_q, ph_d;
  logic                     st_q;

  assign cfg = cfg_t'(cfg_word);

  csf_decode u_dec (.cfg(cfg), .plan(plan), .err(err_d));

  // External operand assembly: wide mode takes low bits from the port 3 pad
  always_comb begin
    if (cfg.wide) ext_p2 = {xin[W-1:0], xin[W +: LSBW]};
    else          ext_p2 = {xin[W-1:0], {LSBW{1'b0}}};
    ext_p3 = {xin[2*W-1:W], {LSBW{1'b0}}};
    ph_d   = ~ph_q;
  end

  for (genvar k = 0; k < NPORT; k++) begin : g_lane
    csf_lane #(.W(W), .LSBW(LSBW)) u_lane (
      .plan   (plan[k]),
      .ch_i   (ch_i),
      .ch_q   (ch_q),
      .ph     (ph_q),
      .ext_p2 (ext_p2),
      .ext_p3 (ext_p3),
      .val    (val[k])
    );
    assign oe_d[k] = plan[k].on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_out <= '0;
      pad_oe  <= '0;
      cfg_err <= 1'b0;
      phase_o <= 1'b0;
      ph_q    <= 1'b0;
      st_q    <= 1'b0;
    end else begin
      pad_out <= val;
      pad_oe  <= oe_d;
      cfg_err <= err_d;
      phase_o <= ph_q;
      ph_q    <= ph_d;
      st_q    <= 1'b1;
    end
  end

  assert_err_all_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (pad_oe == '0 && pad_out == '0));

  assert_phase_alt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_q |=> (phase_o != $past(phase_o)));

  assert_ext_ports_in_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q && !cfg_err && $past(cfg.xsum)) |-> (pad_oe[3:2] == 2'b00));

  for (genvar k = 0; k < NPORT; k++) begin : g_chk
    assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !pad_oe[k] |-> (pad_out[k*W +: W] == '0));
  end
endmodule

// File: tb/chsum_fmt_test.sv
`timescale 1ns/1ps
module chsum_fmt_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_word = '0;
  logic [63:0] ch_i = '0, ch_q = '0;
  logic [31:0] xin = '0;
  logic [63:0] pad_out;
  logic [3:0]  pad_oe;
  logic        phase_o, cfg_err;

  chsum_fmt uut (.clk, .rst_n, .cfg_word, .ch_i, .ch_q, .xin, .pad_out, .pad_oe, .phase_o, .cfg_err);

  always #10 clk = ~clk;

  int errs = 0, checks = 0;
  bit done = 0;
  bit ph = 0;
  logic [15:0] vi[4], vq[4], vp[2];
  logic [15:0] e_dat[4];
  logic [3:0]  e_oe;
  logic        e_err;
  logic [63:0] prev_out = '0;
  logic [3:0]  prev_oe = '0;

  function automatic int sx(input logic [15:0] v);
    return int'($signed(v));
  endfunction

  function automatic logic [15:0] sat16(input int v);
    if (v > 32767) return 16'h7fff;
    if (v < -32768) return 16'h8000;
    return v[15:0];
  endfunction

  function automatic logic [7:0] mkcfg(input int r, input int cx, input int ns, input int xs, input int wd);
    return {wd[0], xs[0], ns[2:0], cx[0], r[1:0]};
  endfunction

  task automatic put(input int p, input int v);
    e_dat[p] = sat16(v);
    e_oe[p] = 1'b1;
  endtask

  task automatic wput(input int v);
    int c;
    c = (v > 2097151) ? 2097151 : ((v < -2097152) ? -2097152 : v);
    e_dat[0] = 16'((c >>> 6) & 32'hffff);
    e_dat[1] = 16'(c & 63);
    e_oe[1:0] = 2'b11;
  endtask

  task automatic model(input logic [7:0] c, input bit p);
    int i0, i1, i2, i3, q0, q1, q2, q3, s0, s1, s2, s3, x2, x3;
    int r, ns;
    bit cx, xs, wd;
    r = int'(c[1:0]); cx = c[2]; ns = int'(c[5:3]); xs = c[6]; wd = c[7];
    i0 = sx(vi[0]); i1 = sx(vi[1]); i2 = sx(vi[2]); i3 = sx(vi[3]);
    q0 = sx(vq[0]); q1 = sx(vq[1]); q2 = sx(vq[2]); q3 = sx(vq[3]);
    s0 = p ? q0 : i0; s1 = p ? q1 : i1; s2 = p ? q2 : i2; s3 = p ? q3 : i3;
    x2 = sx(vp[0]); x3 = sx(vp[1]);
    for (int k = 0; k < 4; k++) e_dat[k] = '0;
    e_oe = '0; e_err = 1'b0;
    if (!xs && !wd) begin
      if (r == 1 && !cx && ns == 4) begin put(0, i0); put(1, i1); put(2, i2); put(3, i3); end
      else if (r == 1 && !cx && ns == 2) begin put(0, i0 + i1); put(1, i2 + i3); end
      else if (r == 1 && !cx && ns == 1) put(0, i0 + i1 + i2 + i3);
      else if (r == 1 && cx && ns == 2) begin put(0, i0 + i1); put(1, q0 + q1); put(2, i2 + i3); put(3, q2 + q3); end
      else if (r == 1 && cx && ns == 1) begin put(0, i0 + i1 + i2 + i3); put(1, q0 + q1 + q2 + q3); end
      else if (r == 0 && cx && ns == 4) begin put(0, s0); put(1, s1); put(2, s2); put(3, s3); end
      else if (r == 0 && cx && ns == 2) begin put(0, s0 + s1); put(1, s2 + s3); end
      else if (r == 0 && cx && ns == 1) put(0, s0 + s1 + s2 + s3);
      else if (r == 2 && !cx && ns == 2) begin put(0, i0); put(1, i1); put(2, i2); put(3, i3); end
      else if (r == 2 && !cx && ns == 1) begin put(0, i0 + i2); put(1, i1 + i3); end
      else if (r == 2 && cx && ns == 1) begin put(0, i0 + i2); put(1, q0 + q2); put(2, i1 + i3); put(3, q1 + q3); end
      else e_err = 1'b1;
    end else if (xs && !wd && ns == 1) begin
      if (r == 1 && !cx) put(0, i0 + i1 + i2 + i3 + x2);
      else if (r == 1 && cx) begin put(0, i0 + i1 + i2 + i3 + x2); put(1, q0 + q1 + q2 + q3 + x3); end
      else if (r == 0 && cx) put(0, s0 + s1 + s2 + s3 + x2);
      else if (r == 2 && !cx) begin put(0, i0 + i2 + x2); put(1, i1 + i3 + x3); end
      else e_err = 1'b1;
    end else if (xs && wd && ns == 1) begin
      if (r == 1 && !cx) wput((i0 + i1 + i2 + i3) * 64 + x2 * 64 + int'(vp[1][5:0]));
      else if (r == 0 && cx) wput((s0 + s1 + s2 + s3) * 64 + x2 * 64 + int'(vp[1][5:0]));
      else e_err = 1'b1;
    end else e_err = 1'b1;
  endtask

  function automatic string tag_of(input logic [7:0] c, input logic er);
    if (er) return "R1";
    if (c[7]) return "R7";
    if (c[6]) return "R6";
    if (c[1:0] == 2'd0) return "R4";
    if (c[1:0] == 2'd2) return "R5";
    if (c[2]) return "R3";
    return "R2";
  endfunction

  task automatic chk(input bit ok, input string tg, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tg, what, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] c, input string tov);
    logic [63:0] eo, msk;
    bit pu;
    string tg;
    cfg_word = c;
    ch_i = {vi[3], vi[2], vi[1], vi[0]};
    ch_q = {vq[3], vq[2], vq[1], vq[0]};
    xin  = {vp[1], vp[0]};
    pu = ph;
    model(c, pu);
    #1;
    // R10: new inputs do not reach the ports before the edge
    chk(pad_out == prev_out && pad_oe == prev_oe, "R10", "pre-edge hold",
        {pad_out[59:0], pad_oe}, {prev_out[59:0], prev_oe});
    @(posedge clk);
    @(negedge clk);
    ph = ~ph;
    eo = {e_dat[3], e_dat[2], e_dat[1], e_dat[0]};
    msk = '0;
    for (int k = 0; k < 4; k++) if (e_oe[k]) msk[k*16 +: 16] = 16'hffff;
    tg = (tov != "") ? tov : tag_of(c, e_err);
    chk((pad_out & msk) == eo && cfg_err == e_err, tg, "data/err",
        {pad_out[62:0], cfg_err}, {eo[62:0], e_err});
    chk(pad_oe == e_oe && (pad_out & ~msk) == '0, "R9", "enables/off ports",
        {pad_out & ~msk, 60'd0} | 64'(pad_oe), 64'(e_oe));
    chk(phase_o == pu, "R4", "phase_o", 64'(phase_o), 64'(pu));
    prev_out = eo;
    prev_oe = e_oe;
  endtask

  task automatic rnd_vals();
    for (int k = 0; k < 4; k++) begin
      vi[k] = 16'($urandom);
      vq[k] = 16'($urandom);
    end
    vp[0] = 16'($urandom);
    vp[1] = 16'($urandom);
  endtask

  task automatic fill(input logic [15:0] a, input logic [15:0] p0, input logic [15:0] p1);
    for (int k = 0; k < 4; k++) begin vi[k] = a; vq[k] = a; end
    vp[0] = p0; vp[1] = p1;
  endtask

  logic [7:0] good[19];
  logic [7:0] bad[9];

  initial begin
    void'($urandom(32'h5eed1234));
    good = '{mkcfg(1,0,4,0,0), mkcfg(1,0,2,0,0), mkcfg(1,0,1,0,0), mkcfg(1,1,2,0,0),
             mkcfg(1,1,1,0,0), mkcfg(0,1,4,0,0), mkcfg(0,1,2,0,0), mkcfg(0,1,1,0,0),
             mkcfg(2,0,2,0,0), mkcfg(2,0,1,0,0), mkcfg(2,1,1,0,0), mkcfg(1,0,1,1,0),
             mkcfg(1,1,1,1,0), mkcfg(0,1,1,1,0), mkcfg(2,0,1,1,0), mkcfg(1,0,1,1,1),
             mkcfg(0,1,1,1,1), mkcfg(1,0,1,0,0), mkcfg(0,1,4,0,0)};
    bad  = '{mkcfg(3,0,1,0,0), mkcfg(0,0,4,0,0), mkcfg(1,0,3,0,0), mkcfg(1,1,4,0,0),
             mkcfg(1,0,1,0,1), mkcfg(1,0,2,1,0), mkcfg(2,1,1,1,0), mkcfg(2,0,1,1,1),
             mkcfg(1,0,0,0,0)};
    #5;
    chk(pad_out == '0 && pad_oe == '0 && cfg_err == 1'b0 && phase_o == 1'b0, "R10", "reset state",
        {pad_out[61:0], cfg_err, phase_o}, 64'd0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    for (int m = 0; m < 19; m++)
      for (int n = 0; n < 20; n++) begin
        rnd_vals();
        step(good[m], "");
      end

    // R8: standard-mode saturation, both ends
    fill(16'h7fff, 16'h7fff, 16'h7fff);
    step(mkcfg(1,0,1,0,0), "R8");
    step(mkcfg(1,1,1,1,0), "R8");
    fill(16'h8000, 16'h8000, 16'h8000);
    step(mkcfg(1,0,1,0,0), "R8");
    step(mkcfg(2,0,1,1,0), "R8");
    // R8: wide-mode saturation, both ends
    fill(16'h7fff, 16'h7fff, 16'h003f);
    step(mkcfg(1,0,1,1,1), "R8");
    fill(16'h8000, 16'h8000, 16'h0000);
    step(mkcfg(0,1,1,1,1), "R8");
    // R7: small wide sum, 4*64+5 -> upper 4, lower 5
    fill(16'h0001, 16'h0000, 16'h0005);
    step(mkcfg(1,0,1,1,1), "R7");
    fill(16'hffff, 16'hffff, 16'h0021);
    step(mkcfg(1,0,1,1,1), "R7");
    // R1: unsupported words
    for (int b = 0; b < 9; b++) begin
      rnd_vals();
      step(bad[b], "R1");
    end
    // R4: consecutive half-rate cycles with fixed inputs
    for (int k = 0; k < 4; k++) begin vi[k] = 16'(k + 1); vq[k] = 16'(100 + k); end
    for (int n = 0; n < 6; n++) step(mkcfg(0,1,4,0,0), "R4");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule